// File: doc/BRIEF.md
# Chained Hardware Watchpoint Unit

The unit watches the core's memory traffic for debug events. Each cycle the core may present one access: a strobe, the kind of access (instruction fetch, load address, store address, load data, store data) and a 32-bit value. Eight programmable comparators test that value against their own reference under a chosen condition. The unit then links the results into a chain of eleven watchpoints, where each one may stand alone, require the one below it, or accept the one below it. Two event counters tally matching watchpoints. Each counter's own equality test against a programmed match value supplies the condition of watchpoints 8 and 9.

The watchpoint vector and the break request are combinational for the access in the current cycle. Counters advance at the following clock edge. All configuration is written through a single-cycle register port. The last watchpoint stands for an external event and is held low.

Register map (word addresses): 0..7 comparator control words; 8..15 comparator reference values; 16 chain fields, two bits per watchpoint k at bits [2k+1:2k] for k = 0..9, with single-step at bit 31; 17 break enables in bits [10:0], counter-routing bits in [26:16], counter 0 enable at bit 30 and counter 1 enable at bit 31; 18 and 19 counters 0 and 1, count in [15:0] and match value in [31:16]. A control word holds present in bit 0, condition in [3:1], signed in bit 4 and compare type in [7:5]. Access kind encoding: 0 fetch, 1 load address, 2 store address, 3 load data, 4 store data.

Top module: `wpt_unit`

## Requirements
- R1: A comparator can hit only when its present bit is 1 and its compare type fits the access. Type 1 fits fetch. Types 2 and 4 fit load address. Types 3 and 4 fit store address. Types 5 and 7 fit load data. Types 6 and 7 fit store data. Type 0 fits nothing.
- R2: With the signed bit 0, the condition compares the access value against the reference as unsigned numbers. The condition codes are 0 for bitwise AND nonzero, 1 equal, 2 not equal, 3 less, 4 less or equal, 5 greater, 6 greater or equal, and 7 never.
- R3: With the signed bit 1, the same conditions compare as two's-complement numbers.
- R4: Chain code 0 gives a watchpoint its own condition. Code 1 ANDs it with the result of the watchpoint below, and code 2 ORs it with that result. Code 3 gives no match. Watchpoint 0 chains with its own condition.
- R5: The own condition of watchpoints 8 and 9 is counter 0 and counter 1, respectively, equal to its match value. Watchpoint 10 never matches.
- R6: At the next clock edge each counter advances by the number of matching watchpoints routed to it: routing bit 0 selects counter 0 and routing bit 1 selects counter 1. A counter advances only when its enable bit is 1. Each watchpoint adds at most one per cycle. A register write loads count and match and overrides counting in that cycle.
- R7: The break request is high when any matching watchpoint has its break enable set.
- R8: When single-step is set, every fetch access raises the break request, whatever the rest of the configuration is.
- R9: Without a strobe, with debug disabled, or with core reset active, no watchpoint matches and no break is raised. With every break enable and routing bit clear, no watchpoint matches.
- R10: After reset all configuration and counters are zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbg_en_i | input | 1 | Debug evaluation enabled |
| core_rst_i | input | 1 | Core is held in reset |
| acc_vld_i | input | 1 | Access strobe |
| acc_type_i | input | 3 | Access kind |
| acc_data_i | input | 32 | Access address or data value |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| brk_o | output | 1 | Break request for this cycle's access |
| wp_o | output | 11 | Watchpoint match vector for this cycle |
| cnt0_o | output | 16 | Counter 0 count |
| cnt1_o | output | 16 | Counter 1 count |

## Verification
On every cycle, the assertions check the following. Idle or gated cycles stay quiet. A break request always has a source, and single-step fetches always break. An AND-chained match implies the match below it, and chain code 3 never matches. A comparator hit implies a present, typed comparator. Counters hold, load, or advance by no more than the watchpoint count. The exact arithmetic of the conditions at the signed and unsigned boundary values needs the bench's sweeps, as do the full chain patterns, the counter sums with mixed routing and the equality hand-off into watchpoints 8 and 9.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

  typedef enum logic [2:0] {
    ACC_FETCH   = 3'd0,
    ACC_LD_ADDR = 3'd1,
    ACC_ST_ADDR = 3'd2,
    ACC_LD_DATA = 3'd3,
    ACC_ST_DATA = 3'd4
  } acc_e;

  typedef enum logic [2:0] {
    CT_OFF     = 3'd0,
    CT_FETCH   = 3'd1,
    CT_LD_ADDR = 3'd2,
    CT_ST_ADDR = 3'd3,
    CT_LS_ADDR = 3'd4,
    CT_LD_DATA = 3'd5,
    CT_ST_DATA = 3'd6,
    CT_LS_DATA = 3'd7
  } ctype_e;

  typedef enum logic [2:0] {
    CC_MASK = 3'd0,
    CC_EQ   = 3'd1,
    CC_NE   = 3'd2,
    CC_LT   = 3'd3,
    CC_LE   = 3'd4,
    CC_GT   = 3'd5,
    CC_GE   = 3'd6,
    CC_NONE = 3'd7
  } cond_e;

  typedef enum logic [1:0] {
    CH_SELF = 2'd0,
    CH_AND  = 2'd1,
    CH_OR   = 2'd2,
    CH_NONE = 2'd3
  } chain_e;

  typedef struct packed {
    ctype_e ctype;
    logic   sgn;
    cond_e  cond;
    logic   present;
  } cmp_ctrl_t;

endpackage

// File: rtl/wpt_cmp.sv
module wpt_cmp
  import wpt_pkg::*;
#(
  parameter int DW = 32
) (
  input  cmp_ctrl_t         ctrl_i,
  input  logic [DW-1:0]     ref_i,
  input  acc_e              acc_i,
  input  logic [DW-1:0]     data_i,
  output logic              hit_o
);

  logic fits, eq, lt, cond_hit;

  always_comb begin
    case (ctrl_i.ctype)
      CT_FETCH:   fits = (acc_i == ACC_FETCH);
      CT_LD_ADDR: fits = (acc_i == ACC_LD_ADDR);
      CT_ST_ADDR: fits = (acc_i == ACC_ST_ADDR);
      CT_LS_ADDR: fits = (acc_i == ACC_LD_ADDR) || (acc_i == ACC_ST_ADDR);
      CT_LD_DATA: fits = (acc_i == ACC_LD_DATA);
      CT_ST_DATA: fits = (acc_i == ACC_ST_DATA);
      CT_LS_DATA: fits = (acc_i == ACC_LD_DATA) || (acc_i == ACC_ST_DATA);
      default:    fits = 1'b0;
    endcase
  end

  assign eq = (data_i == ref_i);
  assign lt = ctrl_i.sgn ? ($signed(data_i) < $signed(ref_i)) : (data_i < ref_i);

  always_comb begin
    case (ctrl_i.cond)
      CC_MASK: cond_hit = |(data_i & ref_i);
      CC_EQ:   cond_hit = eq;
      CC_NE:   cond_hit = !eq;
      CC_LT:   cond_hit = lt;
      CC_LE:   cond_hit = lt || eq;
      CC_GT:   cond_hit = !(lt || eq);
      CC_GE:   cond_hit = !lt;
      default: cond_hit = 1'b0;
    endcase
  end

  assign hit_o = ctrl_i.present && fits && cond_hit;

endmodule

// File: rtl/wpt_chain.sv
module wpt_chain
  import wpt_pkg::*;
#(
  parameter int NCH = 10
) (
  input  logic [NCH-1:0]   own_i,
  input  logic [2*NCH-1:0] chain_i,
  output logic [NCH-1:0]   wp_o
);

  // Single ripple block: stage k links to stage k-1, stage 0 to itself.
  always_comb begin
    logic prev, res;
    prev = own_i[0];
    for (int k = 0; k < NCH; k++) begin
      case (chain_e'(chain_i[2*k +: 2]))
        CH_SELF: res = own_i[k];
        CH_AND:  res = own_i[k] && prev;
        CH_OR:   res = own_i[k] || prev;
        default: res = 1'b0;
      endcase
      wp_o[k] = res;
      prev    = res;
    end
  end

endmodule

// File: rtl/wpt_ctr.sv
module wpt_ctr #(
  parameter int NUM_WP = 11,
  parameter int CW     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_WP-1:0] hit_i,
  input  logic [NUM_WP-1:0] route_i,
  input  logic              en_i,
  input  logic              ld_i,
  input  logic [2*CW-1:0]   ld_data_i,
  output logic [CW-1:0]     cnt_o,
  output logic [CW-1:0]     mt_o
);

  localparam int IW = $clog2(NUM_WP + 1);

  logic [IW-1:0] inc;

  always_comb begin
    inc = '0;
    for (int k = 0; k < NUM_WP; k++) begin
      if (hit_i[k] && route_i[k]) inc = inc + 1'b1;
    end
    if (!en_i) inc = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      mt_o  <= '0;
    end else if (ld_i) begin
      cnt_o <= ld_data_i[CW-1:0];
      mt_o  <= ld_data_i[2*CW-1:CW];
    end else begin
      cnt_o <= cnt_o + CW'(inc);
    end
  end

  a_r6_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !(en_i && |(hit_i & route_i))) |=> $stable(cnt_o));

  a_r6_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (cnt_o == $past(ld_data_i[CW-1:0])));

  a_r6_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> (CW'(cnt_o - $past(cnt_o)) <= CW'(NUM_WP)));

endmodule

// File: rtl/wpt_unit.sv
module wpt_unit
  import wpt_pkg::*;
#(
  parameter int NUM_CMP = 8,
  parameter int DW      = 32,
  parameter int CW      = 16,
  parameter int AW      = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 dbg_en_i,
  input  logic                 core_rst_i,
  input  logic                 acc_vld_i,
  input  logic [2:0]           acc_type_i,
  input  logic [DW-1:0]        acc_data_i,
  input  logic                 reg_we_i,
  input  logic [AW-1:0]        reg_addr_i,
  input  logic [DW-1:0]        reg_wdata_i,
  output logic                 brk_o,
  output logic [NUM_CMP+2:0]   wp_o,
  output logic [CW-1:0]        cnt0_o,
  output logic [CW-1:0]        cnt1_o
);

  localparam int NUM_WP  = NUM_CMP + 3;
  localparam int NCH     = NUM_WP - 1;   // chained stages; the last one is external
  localparam int A_VAL   = NUM_CMP;
  localparam int A_CHAIN = 2 * NUM_CMP;
  localparam int A_MODE  = A_CHAIN + 1;
  localparam int A_CNT   = A_CHAIN + 2;
  localparam int ASG_LSB = DW / 2;
  localparam int CTRL_W  = $bits(cmp_ctrl_t);

  cmp_ctrl_t          ctrl_q [NUM_CMP];
  logic [DW-1:0]      ref_q  [NUM_CMP];
  logic [2*NCH-1:0]   chain_q;
  logic               step_q;
  logic [NUM_WP-1:0]  brk_en_q;
  logic [NUM_WP-1:0]  asg_q;
  logic [1:0]         cnt_en_q;

  acc_e               acc;
  logic               live, cfg_any, eval;
  logic [NUM_CMP-1:0] cmp_hit;
  logic [1:0]         cnt_eq;
  logic [NCH-1:0]     own, chain_out;
  logic [CW-1:0]      cnt_q [2];
  logic [CW-1:0]      mt_q  [2];

  assign acc = acc_e'(acc_type_i);

  // Configuration registers
  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp_regs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_q[k] <= '0;
        ref_q[k]  <= '0;
      end else if (reg_we_i) begin
        if (reg_addr_i == AW'(k))         ctrl_q[k] <= cmp_ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
        if (reg_addr_i == AW'(A_VAL + k)) ref_q[k]  <= reg_wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q  <= '0;
      step_q   <= 1'b0;
      brk_en_q <= '0;
      asg_q    <= '0;
      cnt_en_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == AW'(A_CHAIN)) begin
        chain_q <= reg_wdata_i[2*NCH-1:0];
        step_q  <= reg_wdata_i[DW-1];
      end
      if (reg_addr_i == AW'(A_MODE)) begin
        brk_en_q <= reg_wdata_i[NUM_WP-1:0];
        asg_q    <= reg_wdata_i[ASG_LSB +: NUM_WP];
        cnt_en_q <= reg_wdata_i[DW-1:DW-2];
      end
    end
  end

  // Evaluation gating
  assign live    = acc_vld_i && dbg_en_i && !core_rst_i;
  assign cfg_any = |brk_en_q || |asg_q;
  assign eval    = live && cfg_any;

  // Comparators
  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    wpt_cmp #(.DW(DW)) i_cmp (
      .ctrl_i (ctrl_q[k]),
      .ref_i  (ref_q[k]),
      .acc_i  (acc),
      .data_i (acc_data_i),
      .hit_o  (cmp_hit[k])
    );

    a_r1_hit_needs_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_hit[k] |-> (ctrl_q[k].present && ctrl_q[k].ctype != CT_OFF));
  end

  // Counters feed the last two chained stages
  for (genvar c = 0; c < 2; c++) begin : g_ctr
    logic [NUM_WP-1:0] route;
    assign route = (c == 0) ? ~asg_q : asg_q;

    wpt_ctr #(.NUM_WP(NUM_WP), .CW(CW)) i_ctr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hit_i     (wp_o),
      .route_i   (route),
      .en_i      (cnt_en_q[c]),
      .ld_i      (reg_we_i && (reg_addr_i == AW'(A_CNT + c))),
      .ld_data_i (reg_wdata_i[2*CW-1:0]),
      .cnt_o     (cnt_q[c]),
      .mt_o      (mt_q[c])
    );

    assign cnt_eq[c] = (cnt_q[c] == mt_q[c]);
  end

  assign own = {cnt_eq, cmp_hit} & {NCH{eval}};

  wpt_chain #(.NCH(NCH)) i_chain (
    .own_i   (own),
    .chain_i (chain_q),
    .wp_o    (chain_out)
  );

  assign wp_o   = {1'b0, chain_out};
  assign brk_o  = |(wp_o & brk_en_q) || (live && step_q && acc == ACC_FETCH);
  assign cnt0_o = cnt_q[0];
  assign cnt1_o = cnt_q[1];

  a_r9_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_vld_i || !dbg_en_i || core_rst_i) |-> (wp_o == '0 && !brk_o));

  a_r9_quiet_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_any |-> (wp_o == '0));

  a_r7_brk_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> (|(wp_o & brk_en_q) || (step_q && acc == ACC_FETCH)));

  a_r8_step_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && step_q && acc == ACC_FETCH) |-> brk_o);

  for (genvar k = 1; k < NCH; k++) begin : g_chain_chk
    a_r4_and_needs_prev: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (chain_e'(chain_q[2*k +: 2]) == CH_AND && wp_o[k]) |-> wp_o[k-1]);
    a_r4_code3_never: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (chain_e'(chain_q[2*k +: 2]) == CH_NONE) |-> !wp_o[k]);
  end

endmodule

// File: tb/test_wpt_unit.sv
`timescale 1ns/1ps
module test_wpt_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_en, core_rst, vld, we;
  logic [2:0]  atype;
  logic [31:0] adata, wdata;
  logic [4:0]  waddr;
  logic        brk;
  logic [10:0] wp;
  logic [15:0] c0, c1;

  int checks = 0;
  int errors = 0;

  // Shadow configuration
  logic [7:0]  s_ctrl [8];
  logic [31:0] s_val  [8];
  logic [19:0] s_chain;
  logic        s_step, s_en0, s_en1;
  logic [10:0] s_brk, s_asg;
  logic [15:0] s_cnt [2];
  logic [15:0] s_mt  [2];
  logic [31:0] lf = 32'h1ACE_B00C;
  logic [31:0] vals [6];

  always #2 clk = ~clk;

  wpt_unit i_wpt_unit (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .dbg_en_i    (dbg_en),
    .core_rst_i  (core_rst),
    .acc_vld_i   (vld),
    .acc_type_i  (atype),
    .acc_data_i  (adata),
    .reg_we_i    (we),
    .reg_addr_i  (waddr),
    .reg_wdata_i (wdata),
    .brk_o       (brk),
    .wp_o        (wp),
    .cnt0_o      (c0),
    .cnt1_o      (c1)
  );

  function automatic logic [31:0] nx(input logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic f_hit(input int k, input logic [2:0] t, input logic [31:0] d);
    logic [7:0]  c;
    logic [31:0] v;
    logic fits, lt, r;
    int sa, sb;
    c = s_ctrl[k];
    v = s_val[k];
    case (c[7:5])
      3'd1: fits = (t == 3'd0);
      3'd2: fits = (t == 3'd1);
      3'd3: fits = (t == 3'd2);
      3'd4: fits = (t == 3'd1) || (t == 3'd2);
      3'd5: fits = (t == 3'd3);
      3'd6: fits = (t == 3'd4);
      3'd7: fits = (t == 3'd3) || (t == 3'd4);
      default: fits = 1'b0;
    endcase
    if (c[4]) begin
      sa = int'(d);
      sb = int'(v);
      lt = (sa < sb);
    end else begin
      lt = (d < v);
    end
    case (c[3:1])
      3'd0: r = |(d & v);
      3'd1: r = (d == v);
      3'd2: r = (d != v);
      3'd3: r = lt;
      3'd4: r = lt || (d == v);
      3'd5: r = !lt && (d != v);
      3'd6: r = !lt;
      default: r = 1'b0;
    endcase
    return c[0] && fits && r;
  endfunction

  task automatic model(input logic [2:0] t, input logic [31:0] d, input logic v,
                       input logic de, input logic cr, output logic [10:0] ewp,
                       output logic ebrk, output int i0, output int i1);
    logic live, ev, prev, r;
    logic [9:0] own;
    live = v && de && !cr;
    ev   = live && (|s_brk || |s_asg);
    for (int k = 0; k < 8; k++) own[k] = ev && f_hit(k, t, d);
    own[8] = ev && (s_cnt[0] == s_mt[0]);
    own[9] = ev && (s_cnt[1] == s_mt[1]);
    prev = own[0];
    for (int k = 0; k < 10; k++) begin
      case (s_chain[2*k +: 2])
        2'd0: r = own[k];
        2'd1: r = own[k] && prev;
        2'd2: r = own[k] || prev;
        default: r = 1'b0;
      endcase
      ewp[k] = r;
      prev = r;
    end
    ewp[10] = 1'b0;
    ebrk = |(ewp & s_brk) || (live && s_step && t == 3'd0);
    i0 = s_en0 ? $countones(ewp & ~s_asg) : 0;
    i1 = s_en1 ? $countones(ewp & s_asg) : 0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    vld = 1'b0; we = 1'b1; waddr = 5'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a < 8) s_ctrl[a] = d[7:0];
    else if (a < 16) s_val[a-8] = d;
    else if (a == 16) begin s_chain = d[19:0]; s_step = d[31]; end
    else if (a == 17) begin
      s_brk = d[10:0]; s_asg = d[26:16]; s_en0 = d[30]; s_en1 = d[31];
    end
    else if (a == 18) begin s_cnt[0] = d[15:0]; s_mt[0] = d[31:16]; end
    else if (a == 19) begin s_cnt[1] = d[15:0]; s_mt[1] = d[31:16]; end
  endtask

  task automatic do_acc(input logic [2:0] t, input logic [31:0] d, input logic v,
                        input logic de, input logic cr, input string tag);
    logic [10:0] ewp;
    logic ebrk;
    int i0, i1;
    @(negedge clk);
    atype = t; adata = d; vld = v; dbg_en = de; core_rst = cr;
    #1;
    model(t, d, v, de, cr, ewp, ebrk, i0, i1);
    chk(wp === ewp, tag, "wp_o", 32'(wp), 32'(ewp));
    chk(brk === ebrk, tag, "brk_o", 32'(brk), 32'(ebrk));
    s_cnt[0] = s_cnt[0] + 16'(i0);
    s_cnt[1] = s_cnt[1] + 16'(i1);
    @(posedge clk);
    #1;
    chk(c0 === s_cnt[0], tag, "cnt0_o", 32'(c0), 32'(s_cnt[0]));
    chk(c1 === s_cnt[1], tag, "cnt1_o", 32'(c1), 32'(s_cnt[1]));
  endtask

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL R10 watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    dbg_en = 1'b1; core_rst = 1'b0; vld = 1'b0; we = 1'b0;
    atype = '0; adata = '0; waddr = '0; wdata = '0;
    for (int k = 0; k < 8; k++) begin s_ctrl[k] = '0; s_val[k] = '0; end
    s_chain = '0; s_step = 1'b0; s_en0 = 1'b0; s_en1 = 1'b0;
    s_brk = '0; s_asg = '0;
    for (int c = 0; c < 2; c++) begin s_cnt[c] = '0; s_mt[c] = '0; end
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7FFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h0000_0055;

    // R10: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(wp === 11'd0, "R10", "wp_o", 32'(wp), 32'd0);
    chk(brk === 1'b0, "R10", "brk_o", 32'(brk), 32'd0);
    chk(c0 === 16'd0, "R10", "cnt0_o", 32'(c0), 32'd0);
    chk(c1 === 16'd0, "R10", "cnt1_o", 32'(c1), 32'd0);
    rst_n = 1'b1;

    // Keep counter equality off for now
    wr(18, 32'hFFFF_0000);
    wr(19, 32'hFFFF_0000);
    wr(17, 32'h0000_07FF);

    // R1: type qualification sweep on comparator 0
    wr(8, 32'h0000_1234);
    for (int p = 0; p < 2; p++) begin
      for (int ct = 0; ct < 8; ct++) begin
        wr(0, {24'd0, 3'(ct), 1'b0, 3'd1, 1'(p)});
        for (int a = 0; a < 5; a++) do_acc(3'(a), 32'h0000_1234, 1'b1, 1'b1, 1'b0, "R1");
      end
    end

    // R2 (unsigned) and R3 (signed) condition sweeps
    for (int sg = 0; sg < 2; sg++) begin
      for (int cc = 0; cc < 8; cc++) begin
        wr(0, {24'd0, 3'd4, 1'(sg), 3'(cc), 1'b1});
        for (int vi = 0; vi < 6; vi++) begin
          wr(8, vals[vi]);
          for (int di = 0; di < 6; di++)
            do_acc(3'd1, vals[di], 1'b1, 1'b1, 1'b0, (sg != 0) ? "R3" : "R2");
        end
      end
    end

    // R4 R5 R7: random chains, counter equality and break masks
    for (int k = 0; k < 8; k++) begin
      wr(k, 32'h0000_0023);
      wr(8 + k, 32'(k));
    end
    for (int it = 0; it < 150; it++) begin
      lf = nx(lf);
      wr(16, {12'd0, lf[19:0]});
      lf = nx(lf);
      wr(17, {5'd0, lf[26:16], 5'd0, lf[10:0]});
      lf = nx(lf);
      wr(18, {15'd0, lf[0], 15'd0, lf[1]});
      wr(19, {15'd0, lf[2], 15'd0, lf[3]});
      do_acc(3'd0, {29'd0, lf[6:4]}, 1'b1, 1'b1, 1'b0, "R4 R5 R7");
    end

    // R6: counting with mixed routing and enables
    wr(16, 32'd0);
    wr(18, {16'd6, 16'd0});
    wr(19, {16'd2, 16'd0});
    wr(17, 32'hC0AA_0000);
    for (int it = 0; it < 40; it++) begin
      lf = nx(lf);
      if (it == 15) wr(17, 32'h40F0_0000);
      if (it == 25) wr(17, 32'h800F_0000);
      if (it == 30) wr(18, {16'd3, 16'd1});
      if (it == 32) wr(16, 32'h000A_AAAA);
      do_acc(3'd0, {29'd0, lf[2:0]}, 1'b1, 1'b1, 1'b0, "R6");
    end

    // R8: single step
    wr(17, 32'd0);
    wr(16, 32'h8000_0000);
    for (int a = 0; a < 5; a++) do_acc(3'(a), 32'd0, 1'b1, 1'b1, 1'b0, "R8");
    do_acc(3'd0, 32'd0, 1'b1, 1'b0, 1'b0, "R8");
    do_acc(3'd0, 32'd0, 1'b1, 1'b1, 1'b1, "R8");
    do_acc(3'd0, 32'd0, 1'b0, 1'b1, 1'b0, "R8");

    // R9: gating
    wr(16, 32'd0);
    wr(18, 32'd0);
    wr(17, 32'h4000_07FF);
    do_acc(3'd0, 32'd0, 1'b1, 1'b1, 1'b0, "R9");
    do_acc(3'd0, 32'd0, 1'b1, 1'b0, 1'b0, "R9");
    do_acc(3'd0, 32'd0, 1'b1, 1'b1, 1'b1, "R9");
    do_acc(3'd0, 32'd0, 1'b0, 1'b1, 1'b0, "R9");
    wr(17, 32'hC000_0000);
    do_acc(3'd0, 32'd0, 1'b1, 1'b1, 1'b0, "R9");
    do_acc(3'd1, 32'd0, 1'b1, 1'b1, 1'b0, "R9");

    @(negedge clk);
    vld = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule